// File: doc/BRIEF.md
# I2C Slave Receiver with Clock Stretching

This block is a receive-only I2C slave. It watches an open-drain SCL/SDA pair through two-flop synchronizers and finds START and STOP conditions. After a START it collects a 7-bit address and the direction bit. If the address equals `own_addr` and the direction bit is 0 (write), it acknowledges. It then takes in data bytes, most-significant bit first, and places each one in a single receive buffer. It acknowledges each byte that it stores.

A local host handles the received data through a few signals. It reads the buffer with a one-cycle strobe, and that read clears the buffer-full flag. It also sees a sticky overflow flag and a sticky interrupt flag, and clears each with its own strobe.

Clock stretching can be switched on. When it is on, the slave decides on the falling SCL edge that ends the ninth clock of a byte. It holds SCL low if the byte was acknowledged and the buffer has still not been read. The hold ends when the host pulses the release input. A byte that arrives while the buffer is full is not acknowledged and does not overwrite the buffer. Such a byte never causes a stretch.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset, buf_full, overflow and irq are 0, and neither scl_drive_low nor sda_drive_low is asserted.
- R2: After a START, the slave pulls SDA low during the ninth clock when the first byte is {own_addr, 0}. The address bits come first, MSB first, and the direction bit is last.
- R3: The slave does not acknowledge a first byte whose upper 7 bits differ from own_addr, or whose last bit is 1. It then ignores every byte until the next START: it sends no acknowledge and the buffer is left unchanged.
- R4: The slave shifts in a data byte MSB first and acknowledges it when the buffer is empty. It then shows the byte on rx_data and sets buf_full. A buf_rd pulse clears buf_full.
- R5: A data byte that completes while buf_full is 1 is not acknowledged. It sets overflow and is not stored, so rx_data keeps the earlier byte. overflow stays at 1 until ovf_clr.
- R6: irq is set once the ninth clock of an acknowledged address byte or of any data byte has ended. irq stays at 1 until irq_clr.
- R7: With stretch_en at 1, an acknowledged byte whose buffer is still full when the ninth SCL falls makes the slave hold SCL low. The hold lasts until a rel_wr pulse.
- R8: If the host reads the buffer before the ninth SCL falling edge, the slave does not hold SCL.
- R9: The slave never holds SCL after a byte it did not acknowledge, and never while stretch_en is 0.
- R10: A STOP returns the slave to idle. Bytes clocked after it without a new START get no acknowledge and are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (clock hold) |
| sda_drive_low | output | 1 | Pull SDA low (acknowledge) |
| own_addr | input | 7 | Programmed slave address |
| stretch_en | input | 1 | Enable clock stretching |
| buf_rd | input | 1 | Host read strobe, clears buf_full |
| rel_wr | input | 1 | Host strobe that releases a held SCL |
| ovf_clr | input | 1 | Clears overflow |
| irq_clr | input | 1 | Clears irq |
| rx_data | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | Sticky: a byte arrived while the buffer was full |
| irq | output | 1 | Sticky: a byte's ninth clock has ended |

## Verification
The line levels pass through synchronizers, so each result reaches the outputs two to three clocks after the SCL edge that causes it. The acknowledge drive appears after the eighth falling edge. buf_full, rx_data and overflow also change after the eighth falling edge. irq and the SCL hold change after the ninth falling edge. The bench holds every SCL phase for six clocks and reads the acknowledge halfway through the ninth high phase. It checks the flags and the hold only after the ninth low phase has lasted six clocks. A rel_wr pulse takes effect on the next clock edge, so its check is made one cycle later.

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  input  logic [AW-1:0] own_addr,
  input  logic          stretch_en,
  input  logic          buf_rd,
  input  logic          rel_wr,
  input  logic          ovf_clr,
  input  logic          irq_clr,
  output logic [DW-1:0] rx_data,
  output logic          buf_full,
  output logic          overflow,
  output logic          irq
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] LAST = CW'(DW);
  localparam logic [CW-1:0] ACKC = CW'(DW + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_SKIP} st_t;

  logic [2:0]    scl_s, sda_s;
  st_t           st;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg;
  logic          ckp, ack_q;

  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire start_c  = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire stop_c   = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];
  wire active   = (st == S_ADDR) || (st == S_DATA);
  wire addr_hit = (shreg[DW-1:DW-AW] == own_addr) && !shreg[0];

  assign scl_drive_low = ~ckp;
  assign sda_drive_low = ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_in};
      sda_s <= {sda_s[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ckp      <= 1'b1;
      ack_q    <= 1'b0;
      rx_data  <= '0;
      buf_full <= 1'b0;
      overflow <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (buf_rd)  buf_full <= 1'b0;
      if (ovf_clr) overflow <= 1'b0;
      if (irq_clr) irq      <= 1'b0;
      if (rel_wr)  ckp      <= 1'b1;
      if (start_c || stop_c) begin
        st     <= start_c ? S_ADDR : S_IDLE;
        bitcnt <= '0;
        ack_q  <= 1'b0;
        ckp    <= 1'b1;
      end else if (active && scl_rise) begin
        if (bitcnt < LAST) shreg <= {shreg[DW-2:0], sda_s[1]};
        if (bitcnt <= LAST) bitcnt <= bitcnt + 1'b1;
      end else if (active && scl_fall) begin
        if (bitcnt == LAST) begin
          if (st == S_ADDR) begin
            if (addr_hit) ack_q <= 1'b1;
            else st <= S_SKIP;
          end else if (buf_full) begin
            overflow <= 1'b1;
          end else begin
            rx_data  <= shreg;
            buf_full <= 1'b1;
            ack_q    <= 1'b1;
          end
        end else if (bitcnt == ACKC) begin
          ack_q  <= 1'b0;
          irq    <= 1'b1;
          bitcnt <= '0;
          if (st == S_ADDR) st <= S_DATA;
          if (stretch_en && ack_q && buf_full && !buf_rd) ckp <= 1'b0;
        end
      end
    end
  end
endmodule

module i2c_rx_slave_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_drive_low,
  input logic          sda_drive_low,
  input logic          stretch_en,
  input logic          rel_wr,
  input logic          irq_clr,
  input logic          ovf_clr,
  input logic [DW-1:0] rx_data,
  input logic          buf_full,
  input logic          overflow,
  input logic          irq
);
  AST_STRETCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> ($past(buf_full) && $past(stretch_en) && $past(sda_drive_low))); // R7
  AST_HOLD_UNTIL_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_low && !rel_wr) |=> scl_drive_low); // R7
  AST_NO_OVERFLOW_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> (!sda_drive_low && $stable(rx_data))); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R6
  AST_STORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> buf_full); // R4
endmodule

bind i2c_rx_slave i2c_rx_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
  .stretch_en(stretch_en), .rel_wr(rel_wr), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
  .rx_data(rx_data), .buf_full(buf_full), .overflow(overflow), .irq(irq));

// File: tb/test_i2c_rx_slave.sv
module test_i2c_rx_slave;
  localparam int H = 6;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic stretch_en = 1'b0, buf_rd = 1'b0, rel_wr = 1'b0, ovf_clr = 1'b0, irq_clr = 1'b0;
  logic scl_drive_low, sda_drive_low, buf_full, overflow, irq;
  logic [7:0] rx_data;
  int n_chk = 0, n_fail = 0;
  logic ack;

  wire scl_line = m_scl & ~scl_drive_low;
  wire sda_line = m_sda & ~sda_drive_low;

  always #2 clk = ~clk;

  i2c_rx_slave i_i2c_rx_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .own_addr(OWN), .stretch_en(stretch_en), .buf_rd(buf_rd), .rel_wr(rel_wr),
    .ovf_clr(ovf_clr), .irq_clr(irq_clr), .rx_data(rx_data),
    .buf_full(buf_full), .overflow(overflow), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic start_c();
    m_sda = 1'b1; wt(H); scl_up(); wt(H);
    m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(H);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; wt(H); scl_up(); wt(H);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic send(input logic [7:0] b, input bit rd_in_ack, output logic a);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(H); scl_up(); wt(H); m_scl = 1'b0;
    end
    m_sda = 1'b1; wt(H); scl_up(); wt(H/2);
    a = ~sda_line;
    if (rd_in_ack) pulse(buf_rd);
    wt(H/2); m_scl = 1'b0; wt(H);
  endtask

  initial begin
    int c = 0;
    while (c < 190000) begin @(posedge clk); c++; end
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<190000", c);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wt(4); rst_n = 1'b1; wt(4);
    chk("R1 reset flags", {buf_full, overflow, irq}, 0);
    chk("R1 reset drives", {scl_drive_low, sda_drive_low}, 0);

    // R2 / R3: sweep every address
    for (int a = 0; a < 128; a++) begin
      start_c();
      send({a[6:0], 1'b0}, 0, ack);
      chk($sformatf("R2 ack addr %0h", a), ack, (a == OWN));
      if (a != OWN) begin
        send(8'h33, 0, ack);
        chk("R3 skip byte no ack", ack, 0);
        chk("R3 skip byte not stored", buf_full, 0);
      end else begin
        chk("R6 irq after addr", irq, 1);
        pulse(irq_clr);
      end
      stop_c();
    end
    start_c(); send({OWN, 1'b1}, 0, ack);
    chk("R3 read dir no ack", ack, 0);
    stop_c();

    // R4 / R6: all data values
    start_c(); send({OWN, 1'b0}, 0, ack); pulse(irq_clr);
    for (int d = 0; d < 256; d++) begin
      send(d[7:0], 0, ack);
      chk("R4 ack", ack, 1);
      chk("R4 data", rx_data, d);
      chk("R4 full", buf_full, 1);
      chk("R6 irq", irq, 1);
      chk("R9 no hold when disabled", scl_drive_low, 0);
      wt(3);
      chk("R6 irq sticky", irq, 1);
      pulse(buf_rd); pulse(irq_clr);
      chk("R4 read clears full", buf_full, 0);
      chk("R6 irq clr", irq, 0);
    end

    // R5 overflow
    send(8'hA5, 0, ack); pulse(irq_clr);
    send(8'h3C, 0, ack);
    chk("R5 overflow nack", ack, 0);
    chk("R5 overflow flag", overflow, 1);
    chk("R5 earlier byte kept", rx_data, 8'hA5);
    chk("R6 irq on overflow byte", irq, 1);
    wt(5);
    chk("R5 overflow sticky", overflow, 1);
    pulse(ovf_clr);
    chk("R5 overflow clr", overflow, 0);
    pulse(buf_rd); pulse(irq_clr);

    // R7 stretch
    stretch_en = 1'b1;
    send(8'h81, 0, ack);
    chk("R7 ack", ack, 1);
    chk("R7 hold", scl_drive_low, 1);
    wt(40);
    chk("R7 still held", scl_drive_low, 1);
    chk("R7 data", rx_data, 8'h81);
    pulse(buf_rd);
    chk("R7 read alone keeps hold", scl_drive_low, 0 + 1);
    pulse(rel_wr);
    chk("R7 released", scl_drive_low, 0);

    // R8 read before ninth falling edge
    send(8'h42, 1, ack);
    chk("R8 ack", ack, 1);
    chk("R8 no hold", scl_drive_low, 0);
    chk("R8 data", rx_data, 8'h42);
    chk("R8 full cleared", buf_full, 0);

    // R9 no hold on a byte that was not acknowledged
    send(8'h11, 0, ack);
    chk("R7 hold again", scl_drive_low, 1);
    pulse(rel_wr);
    send(8'h22, 0, ack);
    chk("R9 nack", ack, 0);
    chk("R9 no hold on nack", scl_drive_low, 0);
    chk("R9 data kept", rx_data, 8'h11);
    pulse(ovf_clr);

    // R10 STOP to idle
    stop_c();
    pulse(buf_rd); pulse(irq_clr);
    m_scl = 1'b0; wt(H);
    send(8'h77, 0, ack);
    chk("R10 no ack after stop", ack, 0);
    chk("R10 not stored", buf_full, 0);
    chk("R10 no irq", irq, 0);
    stop_c();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule